// File: doc/BRIEF.md
# Block-Structured Program Image Loader

The loader turns a byte stream holding a program image into writes on a byte-wide memory port covering a 64 KiB address space. The image is a run of records. Each record carries a two-byte base address and a two-byte length, then that many payload bytes. The payload bytes go to consecutive addresses starting at the base.

The stream uses a valid/ready handshake. The end of the image is signalled by a separate marker beat, which is a handshake beat with the end flag set and no data. The memory side is a registered write strobe with an address and a data byte, and the memory may stall it with a ready input.

Once the marker is accepted, the loader reports one of two outcomes. It reports a clean finish if the marker falls between records. It reports a truncated image if the marker falls inside a record. In both cases it stops taking input until it is reset.

Top module: `img_loader`

## Requirements
- R1: After reset, in_ready_o is 1, mem_we_o is 0, done_o is 0 and err_o is 0.
- R2: Both header fields are little endian. A record is laid out as address low byte, address high byte, length low byte, length high byte. The first payload byte is written to the address given by the first two bytes.
- R3: Each later payload byte of a record goes to the address one above the previous one. The address wraps from 0xFFFF to 0x0000.
- R4: Records are parsed one after another. Each payload goes to its own base address, and writes keep the stream order.
- R5: A record with length 0 produces no write. The next accepted data beat is the first byte of the next header.
- R6: If the marker beat arrives at a record boundary, done_o rises on the next cycle and stays high. in_ready_o then stays 0, and no further write is issued.
- R7: If the marker beat arrives inside a header or a payload, err_o rises on the next cycle and stays high. No further write is issued, and in_ready_o stays 0. done_o and err_o are never both 1.
- R8: While mem_we_o is 1 and mem_ready_i is 0, in_ready_o is 0, and mem_addr_o and mem_data_o hold their values until the write is taken.
- R9: A marker beat, meaning in_valid_i and in_eos_i both 1, carries no data. Its in_data_i value has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Stream beat present |
| in_data_i | input | 8 | Stream byte |
| in_eos_i | input | 1 | Beat is the end-of-image marker |
| in_ready_o | output | 1 | Loader accepts a beat this cycle |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | 16 | Memory write byte address |
| mem_data_o | output | 8 | Memory write data |
| mem_ready_i | input | 1 | Memory takes the write this cycle |
| done_o | output | 1 | Image loaded completely (sticky) |
| err_o | output | 1 | Image truncated (sticky) |

## Verification
The bench goes after the following corner cases:
- A base of 0xFFFE with a length of 4. A loader that carries past 16 bits or fails to wrap would write to the wrong addresses.
- A zero-length record. A loader that treats it as a length of 65536, or that swallows a header byte, would misplace every later record.
- Marker beats placed one byte into a header and partway through a payload. A loader that ignores the position would report success, or would keep writing.
- Random gaps on both handshakes. These catch a write that changes under a stall, or input that is accepted while the write slot is full.

// File: rtl/img_loader_pkg.sv
package img_loader_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LEN_W  = ADDR_W;

  typedef enum logic [2:0] {
    PH_ADR0,
    PH_ADR1,
    PH_LEN0,
    PH_LEN1,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/img_loader_parse.sv
module img_loader_parse
  import img_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              eos_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              err_o
);
  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q, err_q;
  logic [LEN_W-1:0]  len_full;

  assign len_full  = {byte_i, len_q[BYTE_W-1:0]};
  assign wr_o      = beat_i && !eos_i && (phase_q == PH_DATA);
  assign wr_addr_o = addr_q;
  assign wr_data_o = byte_i;
  assign done_o    = done_q;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ADR0;
      addr_q  <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (beat_i) begin
      if (eos_i) begin
        if (phase_q == PH_ADR0) done_q <= 1'b1;
        else                    err_q  <= 1'b1;
      end else begin
        unique case (phase_q)
          PH_ADR0: begin
            addr_q[BYTE_W-1:0] <= byte_i;
            phase_q <= PH_ADR1;
          end
          PH_ADR1: begin
            addr_q[ADDR_W-1:BYTE_W] <= byte_i;
            phase_q <= PH_LEN0;
          end
          PH_LEN0: begin
            len_q[BYTE_W-1:0] <= byte_i;
            phase_q <= PH_LEN1;
          end
          PH_LEN1: begin
            len_q   <= len_full;
            phase_q <= (len_full == '0) ? PH_ADR0 : PH_DATA;
          end
          PH_DATA: begin
            addr_q <= addr_q + 1'b1;
            len_q  <= len_q - 1'b1;
            if (len_q == LEN_W'(1)) phase_q <= PH_ADR0;
          end
          default: phase_q <= PH_ADR0;
        endcase
      end
    end
  end
endmodule

// File: rtl/img_loader_wport.sv
module img_loader_wport
  import img_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_data_o,
  output logic              stall_o
);
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;

  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;
  assign stall_o    = we_q && !mem_ready_i;

  // load only arrives when the slot is empty or draining this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      we_q   <= 1'b1;
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (mem_ready_i) begin
      we_q <= 1'b0;
    end
  end
endmodule

// File: rtl/img_loader.sv
module img_loader
  import img_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_eos_i,
  output logic              in_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_data_o,
  input  logic              mem_ready_i,
  output logic              done_o,
  output logic              err_o
);
  logic              beat, stall, wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  assign in_ready_o = !done_o && !err_o && !stall;
  assign beat       = in_valid_i && in_ready_o;

  img_loader_parse u_parse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (beat),
    .byte_i    (in_data_i),
    .eos_i     (in_eos_i),
    .wr_o      (wr),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  img_loader_wport u_wport (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (wr),
    .addr_i      (wr_addr),
    .data_i      (wr_data),
    .mem_ready_i (mem_ready_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .stall_o     (stall)
  );
endmodule

// File: rtl/img_loader_chk.sv
module img_loader_chk
  import img_loader_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BYTE_W-1:0] mem_data_o,
  input logic              mem_ready_i,
  input logic              done_o,
  input logic              err_o
);
  a_r8_ready_low_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_ready_i) |-> !in_ready_o);

  a_r8_write_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_ready_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  a_r7_done_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r6_r7_quiet_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (!mem_we_o && !in_ready_o));
endmodule

bind img_loader img_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/sim_img_loader.sv
`timescale 1ns/1ps
module sim_img_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_eos = 1'b0;
  logic        in_ready;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_ready = 1'b1;
  logic        done, err;

  always #2.5 clk = ~clk;

  img_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_eos_i(in_eos), .in_ready_o(in_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ready_i(mem_ready),
    .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  int s_b[$];
  bit s_e[$];
  int q_a[$], q_d[$];
  int m_ph, m_addr, m_len;
  bit m_done, m_err;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_beat(int b, bit e);
    if (e) begin
      if (m_ph == 0) m_done = 1; else m_err = 1;
      return;
    end
    case (m_ph)
      0: begin m_addr = b; m_ph = 1; end
      1: begin m_addr = m_addr + (b << 8); m_ph = 2; end
      2: begin m_len = b; m_ph = 3; end
      3: begin m_len = m_len + (b << 8); m_ph = (m_len == 0) ? 0 : 4; end
      default: begin
        q_a.push_back(m_addr);
        q_d.push_back(b);
        m_addr = (m_addr + 1) % 65536;
        m_len--;
        if (m_len == 0) m_ph = 0;
      end
    endcase
  endfunction

  task automatic pb(int b);
    s_b.push_back(b); s_e.push_back(1'b0);
  endtask
  task automatic pe(int junk);
    s_b.push_back(junk); s_e.push_back(1'b1);
  endtask
  task automatic rec_hdr(int a, int l);
    pb(a & 255); pb(a >> 8); pb(l & 255); pb(l >> 8);
  endtask

  task automatic run(string tag, bit exp_done, bit exp_err);
    int idx = 0, tail = 0, cyc = 0;
    bit exp_rdy;
    string rtag;
    q_a.delete(); q_d.delete();
    m_ph = 0; m_addr = 0; m_len = 0; m_done = 0; m_err = 0;
    rst_n = 0; in_valid = 0; in_eos = 0; mem_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(mem_we == 1'b0, "R1", "reset mem_we", mem_we, 0);
    chk(done == 1'b0 && err == 1'b0, "R1", "reset done/err", {done, err}, 0);
    while (1) begin
      @(negedge clk);
      if (idx < s_b.size()) begin
        in_valid = ($urandom % 4) != 0;
        in_data  = 8'(s_b[idx]);
        in_eos   = s_e[idx];
      end else begin
        in_valid = 0; in_eos = 0;
      end
      mem_ready = ($urandom % 10) < 7;
      #1;
      exp_rdy = !m_done && !m_err && !(mem_we && !mem_ready);
      rtag = (mem_we && !mem_ready) ? "R8" : m_err ? "R7" : m_done ? "R6" : tag;
      chk(in_ready == exp_rdy, rtag, "in_ready", in_ready, exp_rdy);
      chk(done == m_done, "R6", "done", done, m_done);
      chk(err == m_err, "R7", "err", err, m_err);
      if (mem_we && mem_ready) begin
        if (q_a.size() == 0) chk(0, tag, "unexpected write addr", mem_addr, -1);
        else begin
          chk(mem_addr == 16'(q_a[0]), tag, "write addr", mem_addr, q_a[0]);
          chk(mem_data == 8'(q_d[0]), tag, "write data", mem_data, q_d[0]);
          void'(q_a.pop_front()); void'(q_d.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        model_beat(s_b[idx], s_e[idx]);
        idx++;
      end
      if (m_done || m_err) tail++;
      if (tail > 8) break;
      cyc++;
      if (cyc > 4000) begin chk(0, tag, "scenario timeout", cyc, 4000); break; end
    end
    chk(q_a.size() == 0, tag, "writes missing", q_a.size(), 0);
    chk(done == exp_done, tag, "final done", done, exp_done);
    chk(err == exp_err, tag, "final err", err, exp_err);
    s_b.delete(); s_e.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R2: single record, little-endian header
    rec_hdr(16'h1234, 3); pb(8'h11); pb(8'h22); pb(8'h33); pe(0);
    run("R2", 1, 0);
    // R4: several records to separate bases
    rec_hdr(16'h0100, 2); pb(8'hA1); pb(8'hA2);
    rec_hdr(16'h2000, 1); pb(8'hB1);
    rec_hdr(16'h8003, 3); pb(8'hC1); pb(8'hC2); pb(8'hC3); pe(0);
    run("R4", 1, 0);
    // R5: zero-length record between records
    rec_hdr(16'h0040, 0); rec_hdr(16'h0041, 1); pb(8'h77); pe(0);
    run("R5", 1, 0);
    // R3: wrap at top of address space
    rec_hdr(16'hFFFE, 4); pb(1); pb(2); pb(3); pb(4); pe(0);
    run("R3", 1, 0);
    // R7: end inside header
    pb(8'h10); pe(0); pb(8'h20); pb(8'h30);
    run("R7", 0, 1);
    // R7: end inside payload
    rec_hdr(16'h3000, 5); pb(8'hD1); pb(8'hD2); pe(0); pb(8'hD3); pb(8'hD4);
    run("R7", 0, 1);
    // R6: empty image
    pe(0); pb(8'h55);
    run("R6", 1, 0);
    // R9: marker carrying a nonzero data value
    rec_hdr(16'h0500, 1); pb(8'h99); pe(8'hA5); pb(8'h01);
    run("R9", 1, 0);
    // R8: long burst under random memory stalls
    rec_hdr(16'h4000, 40);
    for (int i = 0; i < 40; i++) pb((i * 7 + 3) & 255);
    pe(0);
    run("R8", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule